// File: doc/BRIEF.md
# Register File with Random-Number Register

A register file for a small five-stage pipelined processor: 32 entries of 29-bit words, two asynchronous read ports and one synchronous write port, all usable in the same clock. The decode stage presents two source indices and receives both operands in the same cycle, while the write-back stage commits one result per clock.

Two indices do not hold storage. Index 0 always reads as zero. Index 16 is a hardware random-number source: it returns the current state of an internal 29-bit linear feedback shift register (LFSR). The LFSR advances on every clock and returns to a fixed nonzero seed on reset. Writes aimed at either of these indices are dropped.

A read that targets the register being written in the same cycle returns the incoming write data rather than the old contents. The write-back result is therefore visible to decode without a separate bypass path.

Top module: `rand_regfile`

## Requirements
- R1: Every storage register holds a full 29-bit word. A value written to any index from 1 to 31, other than 16, reads back unchanged on either read port, including all-ones and alternating bit patterns.
- R2: A synchronous reset clears all storage registers to zero and loads the LFSR with the seed 29'h0000001. In the first cycle after reset, index 16 reads 29'h0000001.
- R3: Reading index 0 on either port always returns zero. A write to index 0 is ignored.
- R4: A write to index 16 is ignored. It does not change the value that index 16 returns.
- R5: Index 16 returns the LFSR state. Each clock not in reset, the state shifts left by one bit, and bit 0 takes bit 28 XOR bit 26 of the old state.
- R6: With the write enable high, the write data is stored at the write index on the rising clock edge. It is readable from the following cycle onwards.
- R7: When both read ports select index 16 in the same cycle, both return the same value.
- R8: When the write enable is high and a read index equals the write index, that read port returns the write data in the same cycle. This does not apply to indices 0 and 16.
- R9: With the write enable low, the write index and write data have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd0_addr | input | 5 | Read index, port 0 |
| rd0_data | output | 29 | Read data, port 0 |
| rd1_addr | input | 5 | Read index, port 1 |
| rd1_data | output | 29 | Read data, port 1 |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write index |
| wr_data | input | 29 | Write data |

## Verification
The bench builds the block with its default parameters. These are 29-bit words, 5-bit indices, the random source at index 16, and feedback taps at bits 28 and 26. With these values, full-width data patterns, the top index 31 and both special indices can all be reached directly. Long random runs with address streams biased toward 0, 16 and the current write index also reach same-cycle collisions: both ports on the random register, a read of the index being written, and writes aimed at the special indices. A mid-run reset brings the seed value back within reach.

// File: rtl/rand_regfile.sv
module rand_regfile #(
  parameter int DATA_W = 29,
  parameter int ADDR_W = 5,
  parameter int RAND_IDX = 16,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 29'h1400_0000,
  parameter logic [DATA_W-1:0] LFSR_SEED = 29'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NREGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ZERO_A = '0;
  localparam logic [ADDR_W-1:0] RAND_A = ADDR_W'(RAND_IDX);

  logic [DATA_W-1:0] regs_q [NREGS];
  logic [DATA_W-1:0] lfsr_q;
  logic              wr_ok;
  logic              fb;

  assign wr_ok = wr_en && (wr_addr != ZERO_A) && (wr_addr != RAND_A);
  assign fb    = ^(lfsr_q & LFSR_TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= LFSR_SEED;
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      lfsr_q <= {lfsr_q[DATA_W-2:0], fb};
      if (wr_ok) regs_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    if (rd0_addr == ZERO_A)                rd0_data = '0;
    else if (rd0_addr == RAND_A)           rd0_data = lfsr_q;
    else if (wr_ok && wr_addr == rd0_addr) rd0_data = wr_data;
    else                                   rd0_data = regs_q[rd0_addr];
  end

  always_comb begin
    if (rd1_addr == ZERO_A)                rd1_data = '0;
    else if (rd1_addr == RAND_A)           rd1_data = lfsr_q;
    else if (wr_ok && wr_addr == rd1_addr) rd1_data = wr_data;
    else                                   rd1_data = regs_q[rd1_addr];
  end

  a_r3_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd0_addr == ZERO_A) |-> (rd0_data == '0));

  a_r5_lfsr_never_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lfsr_q != '0));

  a_r5_rand_moves: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rd0_addr == RAND_A && $past(rd0_addr) == RAND_A)
      |-> (rd0_data != $past(rd0_data)));

  a_r7_rand_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (rd0_addr == RAND_A && rd1_addr == RAND_A) |-> (rd0_data == rd1_data));

  a_r8_forward_port0: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == rd0_addr && rd0_addr != ZERO_A && rd0_addr != RAND_A)
      |-> (rd0_data == wr_data));

  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_ok) && rd1_addr == $past(wr_addr)
      && !(wr_en && wr_addr == rd1_addr))
      |-> (rd1_data == $past(wr_data)));
endmodule

// File: tb/rand_regfile_tb.sv
`timescale 1ns/1ps
module rand_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [28:0] wr_data = '0;
  logic [28:0] rd0_data, rd1_data;

  int checks = 0;
  int failures = 0;
  logic [28:0] mref [32];
  logic [28:0] lref;
  bit ready = 0;

  always #4 clk = ~clk;

  rand_regfile u_dut (
    .clk(clk), .rst(rst),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [28:0] lfsr_step(input logic [28:0] s);
    return {s[27:0], s[28] ^ s[26]};
  endfunction

  function automatic logic [28:0] expect_rd(input logic [4:0] a);
    if (a == 0) return '0;
    if (a == 16) return lref;
    if (wr_en && wr_addr == a) return wr_data;
    return mref[a];
  endfunction

  function automatic string auto_tag(input logic [4:0] a);
    if (a == 0) return "R3";
    if (a == 16) return "R5";
    if (wr_en && wr_addr == a) return "R8";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [28:0] act, input logic [28:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [4:0] wa, input logic [28:0] wd,
                     input logic [4:0] a0, input logic [4:0] a1,
                     input string t0 = "", input string t1 = "");
    @(negedge clk);
    rst = r; wr_en = w; wr_addr = wa; wr_data = wd; rd0_addr = a0; rd1_addr = a1;
    #2;
    if (ready) begin
      chk(t0 == "" ? auto_tag(a0) : t0, rd0_data, expect_rd(a0));
      chk(t1 == "" ? auto_tag(a1) : t1, rd1_data, expect_rd(a1));
      if (a0 == 16 && a1 == 16) chk("R7", rd0_data, rd1_data);
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 32; i++) mref[i] = '0;
      lref = 29'h0000001;
      ready = 1;
    end else begin
      lref = lfsr_step(lref);
      if (w && wa != 0 && wa != 16) mref[wa] = wd;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 16, 16, "R2", "R2");
    for (int i = 0; i < 32; i++) cyc(0, 0, 0, 0, 5'(i), 5'(31 - i), "R2", "R2");
    cyc(0, 1, 31, 29'h1FFF_FFFF, 0, 0);
    cyc(0, 1, 1, 29'h0AAA_AAAA, 31, 0, "R1", "R3");
    cyc(0, 1, 2, 29'h1555_5555, 1, 31, "R1", "R1");
    cyc(0, 0, 0, 0, 2, 1, "R1", "R1");
    cyc(0, 1, 0, 29'h1FFF_FFFF, 0, 0, "R3", "R3");
    cyc(0, 0, 0, 0, 0, 0, "R3", "R3");
    cyc(0, 1, 16, 29'h0123_4567, 16, 16, "R4", "R4");
    cyc(0, 0, 0, 0, 16, 16, "R4", "R4");
    cyc(0, 1, 5, 29'h0BAD_0005, 5, 5, "R8", "R8");
    cyc(0, 0, 0, 0, 5, 16, "R6", "R5");
    cyc(0, 0, 5, 29'h1111_1111, 5, 6, "R9", "R9");
    cyc(0, 0, 6, 29'h0222_2222, 5, 6, "R9", "R9");
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] wa, a0, a1;
      int sel;
      wa = 5'($urandom_range(0, 31));
      sel = $urandom_range(0, 9);
      a0 = (sel < 2) ? 5'd16 : (sel < 3) ? 5'd0 : (sel < 5) ? wa : 5'($urandom_range(0, 31));
      sel = $urandom_range(0, 9);
      a1 = (sel < 2) ? 5'd16 : (sel < 3) ? 5'd0 : (sel < 5) ? wa : 5'($urandom_range(0, 31));
      if (n == 2000) cyc(1, 1, wa, 29'($urandom), a0, a1);
      else cyc(0, 1'($urandom_range(0, 1)), wa, 29'($urandom), a0, a1);
      if (n == 2000) cyc(0, 0, 0, 0, 16, 7, "R2", "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule